// File: doc/BRIEF.md
# Shared Packet Buffer RAM Arbiter

This block lets two masters share one single-ported 2 KB packet buffer RAM. The first master is a serial-engine buffer manager. The second is a low-priority port that a fixed sub-arbiter fills from a DMA requester and a CPU requester, with DMA ranked above the CPU. A mode input `share_en` picks one of two behaviours:

- **`share_en` low.** The serial engine is shut out. The low-priority port sees plain memory with no wait states.
- **`share_en` high.** The serial engine owns every clock edge on which it asks for the RAM. Low-priority accesses are held in a single pending slot for a fixed number of wait cycles. After that, the slot retires on the first edge the serial engine leaves free.

Low-priority writes are posted. The requester is released as soon as the write is taken, and only its next access to the RAM stalls. Low-priority reads block the requester until the data returns.

The serial engine does not use byte addresses. It names a location as an 8-bit buffer pointer with an 8-byte step, plus a word offset. The low-priority ports use byte addresses with a byte/word size bit. Words are little-endian, and a word access always lands on an even address.

Top module: `bufram_arbiter`

## Requirements
- R1: With `share_en` low, an access is accepted in the cycle it is presented, and ready stays high once a cycle has passed with `share_en` low. Read data is valid the cycle after acceptance. A write is visible to the next access.
- R2: With `share_en` low, the serial-engine port has no effect. Its writes leave the RAM unchanged and `sie_rvalid` stays low.
- R3: With `share_en` high, a serial-engine access is carried out on the first clock edge at which `sie_req` is sampled. For a read, `sie_rvalid` and `sie_rdata` are valid in the next cycle, whatever the low-priority port is doing.
- R4: With `share_en` high and no serial-engine traffic, a low-priority access reaches the RAM on the WAIT_CYC-th edge after its accepting edge. WAIT_CYC = MIN_WAIT + CLK_RATIO - 1, which is 4 by default, so a read is 5 cycles from request to data.
- R5: If `sie_req` is high on the edge where a pending low-priority access would retire, that access waits. It retires on the first later edge with `sie_req` low.
- R6: A write with `share_en` high is accepted at once (posted). Ready then stays low until the write retires, so the next access waits. Two writes accept WAIT_CYC+1 cycles apart, whether or not an idle cycle lies between them.
- R7: A read that follows a write to the same address returns the newly written data.
- R8: While `dma_req` is high, `cpu_ready` is low. At most one of `cpu_rvalid` and `dma_rvalid` is high in any cycle.
- R9: Byte and word access use the `*_word` size bit:
  - Word (`*_word`=1): uses `addr[10:1]`, and address bit 0 is ignored.
  - Byte write (`*_word`=0): stores `wdata[7:0]` into bits 7:0 of the word if `addr[0]`=0, or into bits 15:8 if `addr[0]`=1.
  - Byte read: returns that byte zero-extended in `rdata[7:0]`.
- R10: The serial-engine word address is (`sie_ptr`×4 + `sie_off`) modulo 1024, which is byte address `sie_ptr`×8 + 2×`sie_off`. `sie_be[0]` enables bits 7:0 and `sie_be[1]` enables bits 15:8.
- R11: After reset, both low-priority ready outputs are high and no read-valid output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| share_en | input | 1 | 1 = shared mode with arbitration, 0 = plain RAM |
| sie_req | input | 1 | Serial-engine access this cycle |
| sie_we | input | 1 | Serial-engine write |
| sie_ptr | input | 8 | Buffer pointer, 8-byte step |
| sie_off | input | 10 | Word offset added to the pointer |
| sie_be | input | 2 | Serial-engine byte-lane enables |
| sie_wdata | input | 16 | Serial-engine write data |
| sie_rvalid | output | 1 | Serial-engine read data valid |
| sie_rdata | output | 16 | Serial-engine read data |
| dma_req | input | 1 | DMA request |
| dma_we | input | 1 | DMA write |
| dma_word | input | 1 | DMA size: 1 word, 0 byte |
| dma_addr | input | 11 | DMA byte address |
| dma_wdata | input | 16 | DMA write data |
| dma_ready | output | 1 | DMA request accepted at this edge |
| dma_rvalid | output | 1 | DMA read data valid |
| dma_rdata | output | 16 | DMA read data |
| cpu_req | input | 1 | CPU request |
| cpu_we | input | 1 | CPU write |
| cpu_word | input | 1 | CPU size: 1 word, 0 byte |
| cpu_addr | input | 11 | CPU byte address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_ready | output | 1 | CPU request accepted at this edge |
| cpu_rvalid | output | 1 | CPU read data valid |
| cpu_rdata | output | 16 | CPU read data |

## Verification
The bench drives inputs on falling edges and counts falling edges from the moment a request is driven. The expected counts are:

| Case | Counts to result |
|---|---|
| Serial-engine read | one count |
| Read with `share_en` low | one count |
| Read with `share_en` high, no collision | WAIT_CYC+1 counts |
| Same read with serial-engine requests held over the retire edge | pushed back by one count per collided edge |

Write acceptance is time-stamped by rising-edge number. This checks that posted writes are spaced exactly WAIT_CYC+1 edges apart.

During random serial-engine read traffic, every `sie_rvalid` is required one count after its request. Every low-priority read is compared with a reference byte model that the bench updates when it issues each write.

// File: rtl/bufram_arb_pkg.sv
package bufram_arb_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  typedef enum logic {SRC_CPU = 1'b0, SRC_DMA = 1'b1} src_e;

  // lanes touched by a low-priority access
  function automatic logic [LANES-1:0] lane_mask(input logic word, input logic lane);
    if (word) return '1;
    return lane ? 2'b10 : 2'b01;
  endfunction

  // align read data to the requester's size
  function automatic logic [DATA_W-1:0] lane_pick(input logic word, input logic lane,
                                                  input logic [DATA_W-1:0] d);
    if (word) return d;
    return {{LANE_W{1'b0}}, (lane ? d[DATA_W-1:LANE_W] : d[LANE_W-1:0])};
  endfunction
endpackage

// File: rtl/bufram_subarb.sv
module bufram_subarb
  import bufram_arb_pkg::*;
#(
  parameter int ADDR_W = 11,
  localparam int WA = ADDR_W - 1
) (
  input  logic              dma_req,
  input  logic              dma_we,
  input  logic              dma_word,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              dma_ready,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_word,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  input  logic              lp_ready,
  output logic              lp_req,
  output logic              lp_we,
  output logic [LANES-1:0]  lp_be,
  output logic [WA-1:0]     lp_waddr,
  output logic [DATA_W-1:0] lp_wdata,
  output logic              lp_lane,
  output logic              lp_word,
  output src_e              lp_src
);
  logic              sel_dma;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wd;

  assign sel_dma   = dma_req;
  assign dma_ready = lp_ready;
  assign cpu_ready = lp_ready && !dma_req;

  always_comb begin
    lp_req   = dma_req || cpu_req;
    lp_we    = sel_dma ? dma_we   : cpu_we;
    lp_word  = sel_dma ? dma_word : cpu_word;
    addr     = sel_dma ? dma_addr : cpu_addr;
    wd       = sel_dma ? dma_wdata : cpu_wdata;
    lp_src   = sel_dma ? SRC_DMA : SRC_CPU;
    lp_lane  = addr[0];
    lp_waddr = addr[ADDR_W-1:1];
    lp_be    = lane_mask(lp_word, lp_lane);
    lp_wdata = lp_word ? wd : {LANES{wd[LANE_W-1:0]}};
  end
endmodule

// File: rtl/bufram_post.sv
module bufram_post
  import bufram_arb_pkg::*;
#(
  parameter int WA = 10,
  parameter int WAIT_CYC = 4,
  localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              share_en,
  input  logic              sie_busy,
  input  logic              lp_req,
  input  logic              lp_we,
  input  logic [LANES-1:0]  lp_be,
  input  logic [WA-1:0]     lp_waddr,
  input  logic [DATA_W-1:0] lp_wdata,
  input  logic              lp_lane,
  input  logic              lp_word,
  input  src_e              lp_src,
  output logic              lp_ready,
  output logic              acc_go,
  output logic              acc_we,
  output logic [LANES-1:0]  acc_be,
  output logic [WA-1:0]     acc_waddr,
  output logic [DATA_W-1:0] acc_wdata,
  output logic              acc_lane,
  output logic              acc_word,
  output src_e              acc_src
);
  logic              pend_q;
  logic [CW-1:0]     cnt_q;
  logic              we_q, lane_q, word_q;
  logic [LANES-1:0]  be_q;
  logic [WA-1:0]     waddr_q;
  logic [DATA_W-1:0] wdata_q;
  src_e              src_q;
  logic              take, direct, drain, wait_done;

  assign lp_ready  = !pend_q;
  assign take      = lp_req && lp_ready;
  assign direct    = take && !share_en;
  assign wait_done = (cnt_q == CW'(WAIT_CYC - 1));
  assign drain     = pend_q && (!share_en || (wait_done && !sie_busy));
  assign acc_go    = direct || drain;

  always_comb begin
    if (direct) begin
      acc_we = lp_we;  acc_be = lp_be;  acc_waddr = lp_waddr;
      acc_wdata = lp_wdata;  acc_lane = lp_lane;  acc_word = lp_word;  acc_src = lp_src;
    end else begin
      acc_we = we_q;  acc_be = be_q;  acc_waddr = waddr_q;
      acc_wdata = wdata_q;  acc_lane = lane_q;  acc_word = word_q;  acc_src = src_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (take && share_en) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (drain) begin
      pend_q <= 1'b0;
    end else if (pend_q && !wait_done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take && share_en) begin
      we_q <= lp_we;  be_q <= lp_be;  waddr_q <= lp_waddr;
      wdata_q <= lp_wdata;  lane_q <= lp_lane;  word_q <= lp_word;  src_q <= lp_src;
    end
  end
endmodule

// File: rtl/bufram_mem.sv
module bufram_mem
  import bufram_arb_pkg::*;
#(
  parameter int WA = 10,
  localparam int DEPTH = 1 << WA
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [WA-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (en) begin
        if (we && be[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
        rd_q <= mem[addr];
      end
    end
    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/bufram_arbiter.sv
module bufram_arbiter
  import bufram_arb_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PTR_W     = 8,
  parameter int PTR_SHIFT = 2,
  parameter int MIN_WAIT  = 4,
  parameter int CLK_RATIO = 1,
  localparam int WA       = ADDR_W - 1,
  localparam int WAIT_CYC = MIN_WAIT + CLK_RATIO - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              share_en,
  input  logic              sie_req,
  input  logic              sie_we,
  input  logic [PTR_W-1:0]  sie_ptr,
  input  logic [WA-1:0]     sie_off,
  input  logic [LANES-1:0]  sie_be,
  input  logic [DATA_W-1:0] sie_wdata,
  output logic              sie_rvalid,
  output logic [DATA_W-1:0] sie_rdata,
  input  logic              dma_req,
  input  logic              dma_we,
  input  logic              dma_word,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              dma_ready,
  output logic              dma_rvalid,
  output logic [DATA_W-1:0] dma_rdata,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_word,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata
);
  logic              lp_req, lp_we, lp_lane, lp_word, lp_ready;
  logic [LANES-1:0]  lp_be;
  logic [WA-1:0]     lp_waddr;
  logic [DATA_W-1:0] lp_wdata;
  src_e              lp_src;

  logic              acc_go, acc_we, acc_lane, acc_word;
  logic [LANES-1:0]  acc_be;
  logic [WA-1:0]     acc_waddr;
  logic [DATA_W-1:0] acc_wdata;
  src_e              acc_src;

  logic              sie_go;
  logic [WA-1:0]     sie_waddr;
  logic              ram_en, ram_we;
  logic [LANES-1:0]  ram_be;
  logic [WA-1:0]     ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata, lp_rdata;

  logic              sie_rd_q, lp_rd_q, lane_q, word_q;
  src_e              src_q;

  // pointer to word address: each pointer step is 8 bytes
  assign sie_waddr = (WA'(sie_ptr) << PTR_SHIFT) + sie_off;
  assign sie_go    = share_en && sie_req;

  bufram_subarb #(.ADDR_W(ADDR_W)) i_subarb (
    .dma_req(dma_req), .dma_we(dma_we), .dma_word(dma_word), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .dma_ready(dma_ready),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_word(cpu_word), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .lp_ready(lp_ready), .lp_req(lp_req), .lp_we(lp_we), .lp_be(lp_be),
    .lp_waddr(lp_waddr), .lp_wdata(lp_wdata), .lp_lane(lp_lane), .lp_word(lp_word),
    .lp_src(lp_src)
  );

  bufram_post #(.WA(WA), .WAIT_CYC(WAIT_CYC)) i_post (
    .clk(clk), .rst(rst), .share_en(share_en), .sie_busy(sie_go),
    .lp_req(lp_req), .lp_we(lp_we), .lp_be(lp_be), .lp_waddr(lp_waddr),
    .lp_wdata(lp_wdata), .lp_lane(lp_lane), .lp_word(lp_word), .lp_src(lp_src),
    .lp_ready(lp_ready), .acc_go(acc_go), .acc_we(acc_we), .acc_be(acc_be),
    .acc_waddr(acc_waddr), .acc_wdata(acc_wdata), .acc_lane(acc_lane),
    .acc_word(acc_word), .acc_src(acc_src)
  );

  // single RAM port: serial engine first, then the low-priority slot
  always_comb begin
    if (sie_go) begin
      ram_en = 1'b1;  ram_we = sie_we;  ram_be = sie_be;
      ram_addr = sie_waddr;  ram_wdata = sie_wdata;
    end else begin
      ram_en = acc_go;  ram_we = acc_we;  ram_be = acc_be;
      ram_addr = acc_waddr;  ram_wdata = acc_wdata;
    end
  end

  bufram_mem #(.WA(WA)) i_mem (
    .clk(clk), .en(ram_en), .we(ram_we), .be(ram_be), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sie_rd_q <= 1'b0;
      lp_rd_q  <= 1'b0;
    end else begin
      sie_rd_q <= sie_go && !sie_we;
      lp_rd_q  <= !sie_go && acc_go && !acc_we;
    end
  end

  always_ff @(posedge clk) begin
    if (!sie_go && acc_go) begin
      lane_q <= acc_lane;
      word_q <= acc_word;
      src_q  <= acc_src;
    end
  end

  assign lp_rdata   = lane_pick(word_q, lane_q, ram_rdata);
  assign sie_rvalid = sie_rd_q;
  assign sie_rdata  = ram_rdata;
  assign cpu_rvalid = lp_rd_q && (src_q == SRC_CPU);
  assign dma_rvalid = lp_rd_q && (src_q == SRC_DMA);
  assign cpu_rdata  = lp_rdata;
  assign dma_rdata  = lp_rdata;
endmodule

// File: rtl/bufram_arbiter_chk.sv
module bufram_arbiter_chk (
  input logic clk,
  input logic rst,
  input logic share_en,
  input logic sie_req,
  input logic sie_we,
  input logic sie_rvalid,
  input logic dma_req,
  input logic dma_we,
  input logic dma_ready,
  input logic dma_rvalid,
  input logic cpu_req,
  input logic cpu_ready,
  input logic cpu_rvalid
);
  AST_SIE_NO_DELAY: assert property (@(posedge clk) disable iff (rst)
    (share_en && sie_req && !sie_we) |=> sie_rvalid); // R3
  AST_SIE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !share_en |=> !sie_rvalid); // R2
  AST_BYP_READY: assert property (@(posedge clk) disable iff (rst)
    (!share_en ##1 !share_en) |-> dma_ready); // R1
  AST_BYP_RD_LAT: assert property (@(posedge clk) disable iff (rst)
    (!share_en && dma_req && dma_ready && !dma_we) |=> dma_rvalid); // R1
  AST_POST_STALL: assert property (@(posedge clk) disable iff (rst)
    (share_en && cpu_req && cpu_ready) |=> !cpu_ready); // R6
  AST_DMA_FIRST: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> !cpu_ready); // R8
  AST_ONE_RVALID: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_rvalid, dma_rvalid})); // R8
  AST_COLLIDE_YIELD: assert property (@(posedge clk) disable iff (rst)
    (share_en && sie_req) |=> !(cpu_rvalid || dma_rvalid)); // R5
endmodule

bind bufram_arbiter bufram_arbiter_chk i_chk (
  .clk(clk), .rst(rst), .share_en(share_en), .sie_req(sie_req), .sie_we(sie_we),
  .sie_rvalid(sie_rvalid), .dma_req(dma_req), .dma_we(dma_we), .dma_ready(dma_ready),
  .dma_rvalid(dma_rvalid), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .cpu_rvalid(cpu_rvalid)
);

// File: tb/test_bufram_arbiter.sv
`timescale 1ns/1ps
module test_bufram_arbiter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic share_en = 1'b0;
  logic sie_req = 0, sie_we = 0;
  logic [7:0] sie_ptr = 0;
  logic [9:0] sie_off = 0;
  logic [1:0] sie_be = 0;
  logic [15:0] sie_wdata = 0;
  logic sie_rvalid;
  logic [15:0] sie_rdata;
  logic dma_req = 0, dma_we = 0, dma_word = 0;
  logic [10:0] dma_addr = 0;
  logic [15:0] dma_wdata = 0;
  logic dma_ready, dma_rvalid;
  logic [15:0] dma_rdata;
  logic cpu_req = 0, cpu_we = 0, cpu_word = 0;
  logic [10:0] cpu_addr = 0;
  logic [15:0] cpu_wdata = 0;
  logic cpu_ready, cpu_rvalid;
  logic [15:0] cpu_rdata;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] mdl [2048];
  logic sie_rand_on = 0;
  logic done = 0;

  always #5 clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  bufram_arbiter i_bufram_arbiter (
    .clk(clk), .rst(rst), .share_en(share_en),
    .sie_req(sie_req), .sie_we(sie_we), .sie_ptr(sie_ptr), .sie_off(sie_off),
    .sie_be(sie_be), .sie_wdata(sie_wdata), .sie_rvalid(sie_rvalid), .sie_rdata(sie_rdata),
    .dma_req(dma_req), .dma_we(dma_we), .dma_word(dma_word), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .dma_ready(dma_ready), .dma_rvalid(dma_rvalid), .dma_rdata(dma_rdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_word(cpu_word), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [15:0] mdl_rd(input logic word, input logic [10:0] a);
    if (word) return {mdl[{a[10:1], 1'b1}], mdl[{a[10:1], 1'b0}]};
    return {8'h00, mdl[a]};
  endfunction

  // called at a falling edge; returns at a falling edge
  task automatic cpu_op(input logic we, input logic word, input logic [10:0] a,
                        input logic [15:0] d, output logic [15:0] rd,
                        output int lat, output int acc);
    cpu_req = 1; cpu_we = we; cpu_word = word; cpu_addr = a; cpu_wdata = d;
    lat = 0; rd = '0;
    while (!cpu_ready) begin @(negedge clk); lat++; end
    acc = cyc + 1;
    if (we) begin
      if (word) begin mdl[{a[10:1], 1'b0}] = d[7:0]; mdl[{a[10:1], 1'b1}] = d[15:8]; end
      else mdl[a] = d[7:0];
    end
    @(negedge clk); lat++;
    cpu_req = 0;
    if (!we) begin
      while (!cpu_rvalid) begin @(negedge clk); lat++; end
      rd = cpu_rdata;
    end
  endtask

  // table: {we, word, addr, wdata, expected}, all with share_en low
  localparam int NV = 13;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 1'b1, 11'h040, 16'h1234, 16'h0000},
    {1'b0, 1'b1, 11'h040, 16'h0000, 16'h1234},
    {1'b1, 1'b0, 11'h041, 16'h00AB, 16'h0000},
    {1'b0, 1'b1, 11'h040, 16'h0000, 16'hAB34},
    {1'b0, 1'b0, 11'h041, 16'h0000, 16'h00AB},
    {1'b0, 1'b0, 11'h040, 16'h0000, 16'h0034},
    {1'b1, 1'b1, 11'h063, 16'hBEEF, 16'h0000},
    {1'b0, 1'b1, 11'h062, 16'h0000, 16'hBEEF},
    {1'b0, 1'b0, 11'h063, 16'h0000, 16'h00BE},
    {1'b0, 1'b1, 11'h063, 16'h0000, 16'hBEEF},
    {1'b1, 1'b1, 11'h7FE, 16'h0102, 16'h0000},
    {1'b1, 1'b0, 11'h7FE, 16'h00CD, 16'h0000},
    {1'b0, 1'b1, 11'h7FE, 16'h0000, 16'h01CD}
  };

  // background serial-engine read traffic in the upper half
  initial begin
    logic exp_v;
    logic [15:0] exp_d;
    logic drove;
    exp_v = 0; exp_d = 0; drove = 0;
    forever begin
      @(negedge clk);
      if (exp_v) begin
        chk(sie_rvalid === 1'b1, "R3 sie rvalid one cycle late", sie_rvalid, 1);
        chk(sie_rdata === exp_d, "R3 sie read data", sie_rdata, exp_d);
      end
      exp_v = 0;
      if (sie_rand_on) begin
        drove = 1;
        sie_req = $urandom_range(0, 1);
        sie_we = 0; sie_be = 2'b11;
        sie_ptr = 8'($urandom_range(128, 255));
        sie_off = 10'($urandom_range(0, 3));
        if (sie_req) begin
          exp_v = 1;
          exp_d = mdl_rd(1'b1, {sie_ptr, sie_off[1:0], 1'b0});
        end
      end else if (drove) begin
        sie_req = 0; drove = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    report();
  end

  initial begin
    logic [15:0] rd;
    int lat, acc, acc1, acc2;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cpu_ready === 1'b1, "R11 cpu_ready after reset", cpu_ready, 1);
    chk(dma_ready === 1'b1, "R11 dma_ready after reset", dma_ready, 1);
    chk({sie_rvalid, cpu_rvalid, dma_rvalid} === 3'b000, "R11 rvalids after reset",
        {sie_rvalid, cpu_rvalid, dma_rvalid}, 0);

    // fill the RAM with share_en low
    for (int w = 0; w < 1024; w++) cpu_op(1'b1, 1'b1, 11'(w * 2), 16'(w * 40503 + 7), rd, lat, acc);

    // table walk (R1 latency, R9 lanes)
    for (int i = 0; i < NV; i++) begin
      cpu_op(VEC[i][44], VEC[i][43], VEC[i][42:32], VEC[i][31:16], rd, lat, acc);
      if (!VEC[i][44]) begin
        chk(rd === VEC[i][15:0], $sformatf("R9 vector %0d data", i), rd, VEC[i][15:0]);
        chk(lat == 1, $sformatf("R1 vector %0d latency", i), lat, 1);
      end
    end

    // R2: serial engine ignored with share_en low
    sie_req = 1; sie_we = 1; sie_be = 2'b11; sie_ptr = 8'h01; sie_off = 10'd1; sie_wdata = 16'hFFFF;
    @(negedge clk);
    sie_we = 0;
    @(negedge clk);
    chk(sie_rvalid === 1'b0, "R2 no sie rvalid when sharing off", sie_rvalid, 0);
    sie_req = 0;
    cpu_op(1'b0, 1'b1, 11'h00A, 16'h0, rd, lat, acc);
    chk(rd === mdl_rd(1'b1, 11'h00A), "R2 sie write left RAM unchanged", rd, mdl_rd(1'b1, 11'h00A));

    // R8: DMA before CPU
    dma_req = 1; dma_we = 0; dma_word = 1; dma_addr = 11'h040;
    cpu_req = 1; cpu_we = 0; cpu_word = 1; cpu_addr = 11'h062;
    #1;
    chk(cpu_ready === 1'b0 && dma_ready === 1'b1, "R8 cpu held while dma asks",
        {cpu_ready, dma_ready}, 2'b01);
    @(negedge clk);
    dma_req = 0;
    chk(dma_rvalid === 1'b1 && cpu_rvalid === 1'b0, "R8 dma served first",
        {dma_rvalid, cpu_rvalid}, 2'b10);
    chk(dma_rdata === 16'hAB34, "R8 dma read data", dma_rdata, 16'hAB34);
    @(negedge clk);
    cpu_req = 0;
    chk(cpu_rvalid === 1'b1 && cpu_rdata === 16'hBEEF, "R8 cpu served after dma", cpu_rdata, 16'hBEEF);

    // shared mode
    share_en = 1;
    @(negedge clk);
    cpu_op(1'b0, 1'b1, 11'h040, 16'h0, rd, lat, acc);
    chk(lat == 5, "R4 shared read latency", lat, 5);
    chk(rd === 16'hAB34, "R4 shared read data", rd, 16'hAB34);

    // R6: posted writes, with and without an idle cycle between
    cpu_op(1'b1, 1'b1, 11'h100, 16'h1111, rd, lat, acc1);
    chk(lat == 1, "R6 write posted at once", lat, 1);
    cpu_op(1'b1, 1'b1, 11'h102, 16'h2222, rd, lat, acc2);
    chk(acc2 - acc1 == 5, "R6 back-to-back write spacing", acc2 - acc1, 5);
    cpu_op(1'b1, 1'b1, 11'h104, 16'h3333, rd, lat, acc1);
    @(negedge clk);
    cpu_op(1'b1, 1'b1, 11'h106, 16'h4444, rd, lat, acc2);
    chk(acc2 - acc1 == 5, "R6 spacing with idle cycle", acc2 - acc1, 5);

    // R7: read after write, same address
    cpu_op(1'b1, 1'b1, 11'h200, 16'h5A5A, rd, lat, acc);
    cpu_op(1'b0, 1'b1, 11'h200, 16'h0, rd, lat, acc);
    chk(rd === 16'h5A5A, "R7 read returns new data", rd, 16'h5A5A);
    chk(lat == 9, "R7 read waited for drain", lat, 9);

    // R5: collision at the retire edge
    fork
      cpu_op(1'b0, 1'b1, 11'h100, 16'h0, rd, lat, acc);
      begin
        repeat (4) @(negedge clk);
        sie_req = 1; sie_we = 0; sie_be = 2'b11; sie_ptr = 8'h80; sie_off = 0;
        repeat (3) begin
          @(negedge clk);
          chk(sie_rvalid === 1'b1, "R3 sie served during collision", sie_rvalid, 1);
        end
        sie_req = 0;
      end
    join
    chk(lat == 8, "R5 retire pushed past sie edges", lat, 8);
    chk(rd === 16'h1111, "R5 collided read data", rd, 16'h1111);

    // R10: pointer arithmetic and wrap
    sie_req = 1; sie_we = 1; sie_be = 2'b11; sie_ptr = 8'h10; sie_off = 10'd3; sie_wdata = 16'hC0DE;
    @(negedge clk);
    sie_ptr = 8'hFF; sie_off = 10'd5; sie_wdata = 16'h7E57;
    @(negedge clk);
    sie_be = 2'b10; sie_ptr = 8'h20; sie_off = 10'd0; sie_wdata = 16'h99AA;
    @(negedge clk);
    sie_req = 0; sie_we = 0;
    mdl[11'h086] = 8'hDE; mdl[11'h087] = 8'hC0;
    mdl[11'h002] = 8'h57; mdl[11'h003] = 8'h7E;
    mdl[11'h101] = 8'h99;
    cpu_op(1'b0, 1'b1, 11'h086, 16'h0, rd, lat, acc);
    chk(rd === 16'hC0DE, "R10 pointer*8 + 2*offset", rd, 16'hC0DE);
    cpu_op(1'b0, 1'b1, 11'h002, 16'h0, rd, lat, acc);
    chk(rd === 16'h7E57, "R10 address wraps", rd, 16'h7E57);
    cpu_op(1'b0, 1'b1, 11'h100, 16'h0, rd, lat, acc);
    chk(rd === 16'h9911, "R10 sie byte enable", rd, 16'h9911);

    // random serial-engine traffic against the reference model
    sie_rand_on = 1;
    for (int k = 0; k < 150; k++) begin
      logic we, word;
      logic [10:0] a;
      logic [15:0] d, e;
      we = 1'($urandom_range(0, 1));
      word = 1'($urandom_range(0, 1));
      a = we ? 11'($urandom_range(0, 1023)) : 11'($urandom_range(0, 2047));
      d = 16'($urandom);
      e = mdl_rd(word, a);
      cpu_op(we, word, a, d, rd, lat, acc);
      if (!we) chk(rd === e, $sformatf("R4 random read at %h", a), rd, e);
    end
    sie_rand_on = 0;
    repeat (3) @(negedge clk);
    report();
  end
endmodule